// File: doc/BRIEF.md
# Indexed Clock-Chip Register Port with Interrupt Flags

This block is the host-facing side of a real-time clock: a byte port with two addresses. A write to the even address selects one of 128 byte locations, and the odd address reads or writes the selected location. Four locations hold the control and status registers. Control A holds a read-only update-in-progress bit. Control B holds the interrupt enables and the set bit. Status C holds the event flags and is cleared when read. Status D is read-only. Every other location is plain byte storage.

The time-counting and rate-generation logic sits outside the block. It reads control A and B from dedicated outputs. It reports one-cycle pulses for update-ended, alarm and periodic events, plus a pulse that marks the start of an update cycle. The block merges those events with the enables into a request flag, and that flag drives the interrupt line. A system reset input clears the interrupt state without touching the stored bytes.

Top module: `rtc_regport`

## Requirements
- R1: A bus write to address 0 stores bits 6:0 of the data as the index, and bit 7 is dropped. A bus read of address 0 returns 0xFF.
- R2: An index other than 0x0A to 0x0D selects a general-purpose byte, which reads back the last value written to it.
- R3: Writes to status C (index 0x0C) and status D (index 0x0D) have no effect. Status D always reads 0x80.
- R4: Bit 7 of control A (index 0x0A) is the update-in-progress bit. A bus write changes only bits 6:0 of A. A start-of-update pulse sets bit 7, and an update-ended event clears it.
- R5: A read of status C returns its current contents. In the same cycle, C is cleared to 0x00 and the interrupt output drops.
- R6: The events set flags in status C: update-ended sets bit 4, alarm sets bit 5 and periodic sets bit 6. Each flag is set whether or not it is enabled. The request flag (C bit 7) and the interrupt output rise only when a flag is newly set and the enable bit at the same position in control B (index 0x0B) is 1.
- R7: A write to control B that enables a source whose flag is already set raises the request flag and the interrupt output at once. Any other write to B clears the request flag and lowers the output, and leaves the event flags in place.
- R8: A write to control B with bit 7 (set) at 1 stores bit 4 (update enable) as 0 and clears the update-in-progress bit of A.
- R9: After power-up reset, A reads 0x26, B reads 0x02, C reads 0x00, D reads 0x80, and the interrupt output is low.
- R10: A system reset pulse clears bits 6, 5 and 3 of B (periodic, alarm and square-wave enables). It also clears all flags in C and lowers the interrupt output.
- R11: When a read of C and an event fall in the same cycle, the read returns the old contents. The event flag then survives the clear and is treated as newly set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| sysReset | input | 1 | System reset pulse for the interrupt state |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busAddr | input | 1 | 0 selects the index, 1 selects data |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid while busSel is high |
| evtUpdate | input | 1 | Update-ended event pulse |
| evtAlarm | input | 1 | Alarm event pulse |
| evtPeriodic | input | 1 | Periodic event pulse |
| uipSet | input | 1 | Start-of-update pulse |
| ctrlA | output | 8 | Current control A |
| ctrlB | output | 8 | Current control B |
| irqOut | output | 1 | Interrupt request line |

## Verification
The bench targets several ordering cases.
- A flag set while its source is disabled must not raise the line by itself. It must raise the line once a write to B enables that source. A design that checks only newly arriving events would miss this late enable.
- A write to B that disables the pending source must drop the line but keep the flag. A design that clears the whole register would lose the flag.
- A write to B with the set bit on must store the update enable as 0. A later update-ended event must then stay silent.
- A read of C in the same cycle as an alarm must return the old contents and keep the alarm. A design that lets the clear win would lose that interrupt for good.
- A system reset must keep the update enable in B while it clears the other enables.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;

  localparam int DATA_W = 8;

  // Register locations (7-bit index space)
  localparam int LOC_CTRL_A = 10;
  localparam int LOC_CTRL_B = 11;
  localparam int LOC_STAT_C = 12;
  localparam int LOC_STAT_D = 13;

  // Bit positions that other logic depends on
  localparam int BIT_UIP  = 7;  // control A
  localparam int BIT_SET  = 7;  // control B
  localparam int BIT_UEN  = 4;  // control B, update enable
  localparam int BIT_REQ  = 7;  // status C, request flag
  localparam int FLAG_LO  = 4;  // status C / control B, event field low bit
  localparam int FLAG_HI  = 6;  // status C / control B, event field high bit

  localparam logic [DATA_W-1:0] PWRUP_A   = 8'h26;
  localparam logic [DATA_W-1:0] PWRUP_B   = 8'h02;
  localparam logic [DATA_W-1:0] STAT_D_RO = 8'h80;
  localparam logic [DATA_W-1:0] SYSRST_B_CLR = 8'h68;  // periodic, alarm, square-wave enables

  typedef struct packed {
    logic idxWr;
    logic memWr;
    logic aWr;
    logic bWr;
    logic cRd;
  } strobe_t;

endpackage

// File: rtl/rtc_regport_ctrl.sv
module rtc_regport_ctrl
  import rtc_regport_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [IDX_W-1:0]  idx,
  output strobe_t           strb
);

  logic [IDX_W-1:0] idxReg;
  logic dataAcc, hitA, hitB, hitC, hitD, hitSpecial;

  assign dataAcc    = busSel && busAddr;
  assign hitA       = (idxReg == IDX_W'(LOC_CTRL_A));
  assign hitB       = (idxReg == IDX_W'(LOC_CTRL_B));
  assign hitC       = (idxReg == IDX_W'(LOC_STAT_C));
  assign hitD       = (idxReg == IDX_W'(LOC_STAT_D));
  assign hitSpecial = hitA || hitB || hitC || hitD;

  always_comb begin
    strb       = '0;
    strb.idxWr = busSel && !busAddr && busWr;
    strb.aWr   = dataAcc && busWr && hitA;
    strb.bWr   = dataAcc && busWr && hitB;
    strb.memWr = dataAcc && busWr && !hitSpecial;
    strb.cRd   = dataAcc && !busWr && hitC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxReg <= '0;
    else if (strb.idxWr) idxReg <= busWdata[IDX_W-1:0];
  end

  assign idx = idxReg;

  // R1 / R3: at most one action per access; writes to C or D raise no strobe
  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.idxWr, strb.memWr, strb.aWr, strb.bWr, strb.cRd}));

endmodule

// File: rtl/rtc_regport_regs.sv
module rtc_regport_regs
  import rtc_regport_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysReset,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  idx,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              evtUpdate,
  input  logic              evtAlarm,
  input  logic              evtPeriodic,
  input  logic              uipSet,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] aReg,
  output logic [DATA_W-1:0] bReg,
  output logic              irq
);

  localparam int DEPTH  = 1 << IDX_W;
  localparam int NFLAGS = FLAG_HI - FLAG_LO + 1;

  logic [DATA_W-1:0] cReg;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] aNext, bNext, cNext, cBus, bWrData;
  logic [NFLAGS-1:0] evtVec, freshFlags;
  logic anyEvt;

  assign evtVec = {evtPeriodic, evtAlarm, evtUpdate};
  assign anyEvt = |evtVec;

  always_comb begin
    // set bit forces the update enable off in the stored value
    bWrData = busWdata;
    if (busWdata[BIT_SET]) bWrData[BIT_UEN] = 1'b0;

    // control A: bus owns bits 6:0, bit 7 follows the update cycle
    aNext = aReg;
    if (strb.aWr) aNext[BIT_UIP-1:0] = busWdata[BIT_UIP-1:0];
    if (strb.bWr && busWdata[BIT_SET]) aNext[BIT_UIP] = 1'b0;
    else if (evtUpdate)                aNext[BIT_UIP] = 1'b0;
    else if (uipSet)                   aNext[BIT_UIP] = 1'b1;

    // control B
    bNext = strb.bWr ? bWrData : bReg;

    // status C: bus effect first, events on top
    cBus = strb.cRd ? '0 : cReg;
    if (strb.bWr)
      cBus[BIT_REQ] = |(bWrData[FLAG_HI:FLAG_LO] & cReg[FLAG_HI:FLAG_LO]);

    freshFlags = evtVec & ~cBus[FLAG_HI:FLAG_LO];
    cNext = cBus;
    cNext[FLAG_HI:FLAG_LO] = cBus[FLAG_HI:FLAG_LO] | evtVec;
    if (|(freshFlags & bNext[FLAG_HI:FLAG_LO])) cNext[BIT_REQ] = 1'b1;

    if (sysReset) begin
      bNext = bNext & ~SYSRST_B_CLR;
      cNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= PWRUP_A;
      bReg <= PWRUP_B;
      cReg <= '0;
    end else begin
      aReg <= aNext;
      bReg <= bNext;
      cReg <= cNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.memWr) mem[idx] <= busWdata;
  end

  always_comb begin
    if (!busAddr) rdata = '1;
    else begin
      case (int'(idx))
        LOC_CTRL_A: rdata = aReg;
        LOC_CTRL_B: rdata = bReg;
        LOC_STAT_C: rdata = cReg;
        LOC_STAT_D: rdata = STAT_D_RO;
        default:    rdata = mem[idx];
      endcase
    end
  end

  assign irq = cReg[BIT_REQ];

  // R5: a read of C with no event pending leaves C empty and the line low
  assert_c_read_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cRd && !anyEvt) |=> (cReg == '0 && !irq));

  // R4: bus writes to A never move the update-in-progress bit
  assert_uip_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.aWr && !uipSet && !evtUpdate && !strb.bWr) |=> (aReg[BIT_UIP] == $past(aReg[BIT_UIP])));

  // R8: set bit in a B write leaves update enable and UIP at 0
  assert_set_forces_uen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bWr && busWdata[BIT_SET]) |=> (!bReg[BIT_UEN] && !aReg[BIT_UIP]));

  // R10: system reset clears the flags and the selected enables
  assert_sysreset_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> (cReg == '0 && (bReg & SYSRST_B_CLR) == '0 && !irq));

  // R6: every event leaves its flag set in C
  assert_flag_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (anyEvt && !sysReset) |=> ((cReg[FLAG_HI:FLAG_LO] & $past(evtVec)) == $past(evtVec)));

  // R6 / R7: the line rises only after an event or a write to B
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strb.bWr || anyEvt));

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sysReset,
  input  logic       busSel,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       evtUpdate,
  input  logic       evtAlarm,
  input  logic       evtPeriodic,
  input  logic       uipSet,
  output logic [7:0] ctrlA,
  output logic [7:0] ctrlB,
  output logic       irqOut
);

  logic [IDX_W-1:0] idx;
  strobe_t          strb;

  rtc_regport_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .idx      (idx),
    .strb     (strb)
  );

  rtc_regport_regs #(.IDX_W(IDX_W)) uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .sysReset    (sysReset),
    .strb        (strb),
    .idx         (idx),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .evtUpdate   (evtUpdate),
    .evtAlarm    (evtAlarm),
    .evtPeriodic (evtPeriodic),
    .uipSet      (uipSet),
    .rdata       (busRdata),
    .aReg        (ctrlA),
    .bReg        (ctrlB),
    .irq         (irqOut)
  );

endmodule

// File: tb/tb_rtc_regport.sv
`timescale 1ns/1ps
module tb_rtc_regport;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sysReset = 1'b0;
  logic       busSel = 1'b0;
  logic       busAddr = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       evtUpdate = 1'b0, evtAlarm = 1'b0, evtPeriodic = 1'b0, uipSet = 1'b0;
  logic [7:0] ctrlA, ctrlB;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_regport dut (
    .clk(clk), .rstN(rstN), .sysReset(sysReset),
    .busSel(busSel), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata),
    .evtUpdate(evtUpdate), .evtAlarm(evtAlarm), .evtPeriodic(evtPeriodic),
    .uipSet(uipSet), .ctrlA(ctrlA), .ctrlB(ctrlB), .irqOut(irqOut)
  );

  // op codes
  localparam logic [7:0] OP_IDX = 8'd1;  // write index
  localparam logic [7:0] OP_WR  = 8'd2;  // write data
  localparam logic [7:0] OP_RD  = 8'd3;  // read data, compare
  localparam logic [7:0] OP_EVT = 8'd4;  // bit0 update, bit1 alarm, bit2 periodic, bit3 uipSet
  localparam logic [7:0] OP_IRQ = 8'd5;  // compare irq line
  localparam logic [7:0] OP_RDE = 8'd6;  // read even address, compare

  // {op, data, expected, requirement}
  localparam logic [31:0] VEC [64] = '{
    {OP_IDX, 8'h0A, 8'h00, 8'd9}, {OP_RD, 8'h00, 8'h26, 8'd9},   // R9
    {OP_IDX, 8'h0B, 8'h00, 8'd9}, {OP_RD, 8'h00, 8'h02, 8'd9},   // R9
    {OP_IDX, 8'h0C, 8'h00, 8'd9}, {OP_RD, 8'h00, 8'h00, 8'd9},   // R9
    {OP_IRQ, 8'h00, 8'h00, 8'd9},                                // R9
    {OP_IDX, 8'h0D, 8'h00, 8'd9}, {OP_RD, 8'h00, 8'h80, 8'd9},   // R9
    {OP_IDX, 8'h8E, 8'h00, 8'd1}, {OP_WR, 8'h5A, 8'h00, 8'd1},   // R1 masked index
    {OP_IDX, 8'h0E, 8'h00, 8'd1}, {OP_RD, 8'h00, 8'h5A, 8'd1},   // R1
    {OP_RDE, 8'h00, 8'hFF, 8'd1},                                // R1
    {OP_IDX, 8'h40, 8'h00, 8'd2}, {OP_WR, 8'hC3, 8'h00, 8'd2},   // R2
    {OP_IDX, 8'h7F, 8'h00, 8'd2}, {OP_WR, 8'h11, 8'h00, 8'd2},   // R2
    {OP_IDX, 8'h40, 8'h00, 8'd2}, {OP_RD, 8'h00, 8'hC3, 8'd2},   // R2
    {OP_IDX, 8'h7F, 8'h00, 8'd2}, {OP_RD, 8'h00, 8'h11, 8'd2},   // R2
    {OP_IDX, 8'h0D, 8'h00, 8'd3}, {OP_WR, 8'h00, 8'h00, 8'd3},   // R3
    {OP_RD,  8'h00, 8'h80, 8'd3},                                // R3
    {OP_IDX, 8'h0C, 8'h00, 8'd3}, {OP_WR, 8'hFF, 8'h00, 8'd3},   // R3
    {OP_RD,  8'h00, 8'h00, 8'd3}, {OP_IRQ, 8'h00, 8'h00, 8'd3},  // R3
    {OP_EVT, 8'h08, 8'h00, 8'd4},                                // R4 uipSet
    {OP_IDX, 8'h0A, 8'h00, 8'd4}, {OP_RD, 8'h00, 8'hA6, 8'd4},   // R4
    {OP_WR,  8'h05, 8'h00, 8'd4}, {OP_RD, 8'h00, 8'h85, 8'd4},   // R4
    {OP_EVT, 8'h01, 8'h00, 8'd4}, {OP_RD, 8'h00, 8'h05, 8'd4},   // R4 update clears UIP
    {OP_IDX, 8'h0C, 8'h00, 8'd6}, {OP_RD, 8'h00, 8'h10, 8'd6},   // R6 flag without enable
    {OP_IRQ, 8'h00, 8'h00, 8'd6}, {OP_RD, 8'h00, 8'h00, 8'd5},   // R6, R5
    {OP_IDX, 8'h0B, 8'h00, 8'd7}, {OP_WR, 8'h22, 8'h00, 8'd7},   // R7
    {OP_IRQ, 8'h00, 8'h00, 8'd7},                                // R7
    {OP_EVT, 8'h02, 8'h00, 8'd6}, {OP_IRQ, 8'h00, 8'h01, 8'd6},  // R6 enabled alarm
    {OP_IDX, 8'h0C, 8'h00, 8'd5}, {OP_RD, 8'h00, 8'hA0, 8'd5},   // R5
    {OP_IRQ, 8'h00, 8'h00, 8'd5}, {OP_RD, 8'h00, 8'h00, 8'd5},   // R5
    {OP_EVT, 8'h04, 8'h00, 8'd6}, {OP_IRQ, 8'h00, 8'h00, 8'd6},  // R6 periodic disabled
    {OP_IDX, 8'h0B, 8'h00, 8'd7}, {OP_WR, 8'h62, 8'h00, 8'd7},   // R7 late enable
    {OP_IRQ, 8'h00, 8'h01, 8'd7},                                // R7
    {OP_IDX, 8'h0C, 8'h00, 8'd7}, {OP_RD, 8'h00, 8'hC0, 8'd7},   // R7
    {OP_IRQ, 8'h00, 8'h00, 8'd5},                                // R5
    {OP_EVT, 8'h04, 8'h00, 8'd6}, {OP_IRQ, 8'h00, 8'h01, 8'd6},  // R6
    {OP_IDX, 8'h0B, 8'h00, 8'd7}, {OP_WR, 8'h22, 8'h00, 8'd7},   // R7 disable drops line
    {OP_IRQ, 8'h00, 8'h00, 8'd7},                                // R7
    {OP_IDX, 8'h0C, 8'h00, 8'd7}, {OP_RD, 8'h00, 8'h40, 8'd7}    // R7 flag kept
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic busOp(input logic a, input logic w, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    busSel = 1'b1; busAddr = a; busWr = w; busWdata = d;
    #2 r = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic evtOp(input logic [3:0] e);
    @(negedge clk);
    {uipSet, evtPeriodic, evtAlarm, evtUpdate} = e;
    @(posedge clk);
    #1 {uipSet, evtPeriodic, evtAlarm, evtUpdate} = '0;
  endtask

  task automatic irqCheck(input logic exp, input int req);
    @(negedge clk);
    check({7'd0, irqOut}, {7'd0, exp}, req, "irq line");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    for (int i = 0; i < 64; i++) begin
      logic [7:0] op, dat, exp;
      int req;
      op = VEC[i][31:24]; dat = VEC[i][23:16]; exp = VEC[i][15:8]; req = int'(VEC[i][7:0]);
      case (op)
        OP_IDX: busOp(1'b0, 1'b1, dat, r);
        OP_WR:  busOp(1'b1, 1'b1, dat, r);
        OP_RD:  begin busOp(1'b1, 1'b0, 8'h00, r); check(r, exp, req, "data read"); end
        OP_RDE: begin busOp(1'b0, 1'b0, 8'h00, r); check(r, exp, req, "index read"); end
        OP_EVT: evtOp(dat[3:0]);
        OP_IRQ: irqCheck(exp[0], req);
        default: ;
      endcase
    end

    // R8: set bit forces update enable off and clears UIP
    evtOp(4'b1000);
    busOp(1'b0, 1'b1, 8'h0B, r);
    busOp(1'b1, 1'b1, 8'h92, r);
    busOp(1'b1, 1'b0, 8'h00, r); check(r, 8'h82, 8, "B after set write");
    busOp(1'b0, 1'b1, 8'h0A, r);
    busOp(1'b1, 1'b0, 8'h00, r); check(r, 8'h05, 8, "A UIP cleared by set");
    evtOp(4'b0001);
    irqCheck(1'b0, 8);                                   // R8 update enable stayed off
    busOp(1'b0, 1'b1, 8'h0C, r);
    busOp(1'b1, 1'b0, 8'h00, r); check(r, 8'h10, 6, "UF flag only");

    // R11: read of C and alarm in the same cycle
    busOp(1'b0, 1'b1, 8'h0B, r);
    busOp(1'b1, 1'b1, 8'h22, r);
    busOp(1'b0, 1'b1, 8'h0C, r);
    @(negedge clk);
    busSel = 1'b1; busAddr = 1'b1; busWr = 1'b0; evtAlarm = 1'b1;
    #2 r = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0; evtAlarm = 1'b0;
    check(r, 8'h00, 11, "C read during alarm");
    irqCheck(1'b1, 11);                                  // R11 alarm survives
    busOp(1'b1, 1'b0, 8'h00, r); check(r, 8'hA0, 11, "C after collision");

    // R10: system reset
    busOp(1'b0, 1'b1, 8'h0B, r);
    busOp(1'b1, 1'b1, 8'h7A, r);
    evtOp(4'b0010);
    irqCheck(1'b1, 10);
    @(negedge clk); sysReset = 1'b1;
    @(posedge clk); #1 sysReset = 1'b0;
    irqCheck(1'b0, 10);
    busOp(1'b1, 1'b0, 8'h00, r); check(r, 8'h12, 10, "B after system reset");
    busOp(1'b0, 1'b1, 8'h0C, r);
    busOp(1'b1, 1'b0, 8'h00, r); check(r, 8'h00, 10, "C after system reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule